// File: doc/BRIEF.md
# Cache-Line Access Splitter

This block takes one memory access, given as a start address, a byte count and a command, and turns it into a series of sub-requests. No sub-request spans a cache-line boundary. The first piece runs from the start address up to the next line boundary, or to the end of the access if that comes first. Every later piece starts on a line boundary and covers a full line, except the final remainder. Each piece carries its address, its byte count, the command, and its byte position within the caller's data buffer. Pieces leave in ascending address order, so that position is the sum of the sizes issued before it.

The caller offers a request over a valid/ready pair. The block takes a request only when it has no pieces outstanding. Pieces go out over a second valid/ready pair, and each piece stays unchanged until the receiver takes it. A one-cycle completion pulse follows the last piece. A request with a byte count of zero gives no pieces and only the completion pulse. A request whose command is neither read nor write gives no pieces and raises a one-cycle error pulse. The line size is a power-of-two parameter.

Top module: `line_chunker`

## Requirements
- R1: While reset is high and in the first cycle after it, `piece_valid`, `finish` and `bad_cmd` are 0 and `req_ready` is 1.
- R2: `req_ready` is 1 exactly when no piece is outstanding. While a piece is outstanding, `req_valid` is ignored and `req_ready` stays 0.
- R3: One cycle after a legal request with nonzero length is taken, the first piece appears. Its address is the request address, its offset is 0, and its size is min(length, LINE_BYTES − (address mod LINE_BYTES)). A valid piece never has size 0.
- R4: Every piece after the first starts at an address that is a multiple of LINE_BYTES and has size min(remaining bytes, LINE_BYTES). No piece's bytes cross a line boundary.
- R5: Each piece's offset equals the sum of the sizes of the earlier pieces of the same request. Each piece's address equals the previous piece's address plus the previous piece's size.
- R6: While `piece_valid` is 1 and `piece_ready` is 0, every piece field stays unchanged on the next cycle.
- R7: Command encoding: 2'b00 is read and 2'b01 is write. Every piece carries the request's command unchanged.
- R8: A taken request whose command has bit 1 set (2'b10 or 2'b11) gives a one-cycle `bad_cmd` pulse in the cycle after acceptance. It produces no pieces and no `finish`, and the block stays ready.
- R9: A taken legal request with length 0 gives a one-cycle `finish` pulse in the cycle after acceptance and produces no pieces.
- R10: `piece_last` is 1 only on the final piece of a request. One cycle after that piece is taken, `finish` is 1 for one cycle, `piece_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The block is idle and takes a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_cmd | input | 2 | Command: 00 read, 01 write, others illegal |
| piece_valid | output | 1 | A piece is presented |
| piece_ready | input | 1 | Receiver takes the piece |
| piece_addr | output | ADDR_W | Piece start address |
| piece_size | output | log2(LINE_BYTES)+1 | Piece byte count |
| piece_offset | output | LEN_W | Piece position within the caller's buffer |
| piece_cmd | output | 2 | Command copied from the request |
| piece_last | output | 1 | Final piece of the request |
| finish | output | 1 | One-cycle completion pulse |
| bad_cmd | output | 1 | One-cycle illegal-command pulse |

## Verification
The bench builds the block with LINE_BYTES = 16, LEN_W = 8 and ADDR_W = 32. With these values a single request can span up to seventeen lines. That brings into reach short first pieces at every alignment, long runs of full-line pieces, remainders of every size, and requests that end exactly on a boundary. Random receiver stalls, combined with request attempts made while pieces are still outstanding, test the hold and ignore rules. Illegal commands and zero lengths are mixed into the random stream.

// File: rtl/lc_pkg.sv
package lc_pkg;

  // Command encoding seen on req_cmd / piece_cmd
  localparam logic [1:0] LC_CMD_READ  = 2'b00;
  localparam logic [1:0] LC_CMD_WRITE = 2'b01;

  typedef enum logic {
    LC_IDLE  = 1'b0,
    LC_ISSUE = 1'b1
  } lc_state_e;

endpackage

// File: rtl/lc_cmd_check.sv
module lc_cmd_check (
  input  logic [1:0] cmd,
  output logic       legal
);
  import lc_pkg::*;

  always_comb begin
    legal = (cmd == LC_CMD_READ) || (cmd == LC_CMD_WRITE);
  end

endmodule

// File: rtl/lc_piece_calc.sv
// Size of the piece that starts at 'addr' given 'remaining' bytes left.
// LEN_W must exceed log2(LINE_BYTES); LINE_BYTES must be at least 2.
module lc_piece_calc #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 64,
  localparam int LINE_LOG2 = $clog2(LINE_BYTES),
  localparam int SIZE_W    = LINE_LOG2 + 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remaining,
  output logic [SIZE_W-1:0] size,
  output logic [LEN_W-1:0]  rem_after
);

  logic [SIZE_W-1:0] room;
  logic [LEN_W-1:0]  room_w;

  always_comb begin
    room      = SIZE_W'(LINE_BYTES) - {1'b0, addr[LINE_LOG2-1:0]};
    room_w    = LEN_W'(room);
    size      = (remaining < room_w) ? remaining[SIZE_W-1:0] : room;
    rem_after = remaining - LEN_W'(size);
  end

endmodule

// File: rtl/line_chunker.sv
module line_chunker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 64,
  localparam int LINE_LOG2 = $clog2(LINE_BYTES),
  localparam int SIZE_W    = LINE_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [1:0]        req_cmd,
  output logic              piece_valid,
  input  logic              piece_ready,
  output logic [ADDR_W-1:0] piece_addr,
  output logic [SIZE_W-1:0] piece_size,
  output logic [LEN_W-1:0]  piece_offset,
  output logic [1:0]        piece_cmd,
  output logic              piece_last,
  output logic              finish,
  output logic              bad_cmd
);
  import lc_pkg::*;

  lc_state_e         state_q;
  logic [LEN_W-1:0]  rem_q;
  logic              cmd_legal;
  logic [ADDR_W-1:0] calc_addr;
  logic [LEN_W-1:0]  calc_rem;
  logic [SIZE_W-1:0] calc_size;
  logic [LEN_W-1:0]  calc_rem_after;
  logic              take_piece;

  lc_cmd_check u_cmd_check (
    .cmd   (req_cmd),
    .legal (cmd_legal)
  );

  // While idle the calculator sees the new request; while issuing it
  // sees the address just past the presented piece.
  always_comb begin
    if (state_q == LC_ISSUE) begin
      calc_addr = piece_addr + ADDR_W'(piece_size);
      calc_rem  = rem_q;
    end else begin
      calc_addr = req_addr;
      calc_rem  = req_len;
    end
  end

  lc_piece_calc #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .LINE_BYTES (LINE_BYTES)
  ) u_piece_calc (
    .addr      (calc_addr),
    .remaining (calc_rem),
    .size      (calc_size),
    .rem_after (calc_rem_after)
  );

  assign req_ready  = (state_q == LC_IDLE);
  assign take_piece = piece_valid & piece_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= LC_IDLE;
      piece_valid  <= 1'b0;
      piece_addr   <= '0;
      piece_size   <= '0;
      piece_offset <= '0;
      piece_cmd    <= LC_CMD_READ;
      piece_last   <= 1'b0;
      rem_q        <= '0;
      finish       <= 1'b0;
      bad_cmd      <= 1'b0;
    end else begin
      finish  <= 1'b0;
      bad_cmd <= 1'b0;
      if (state_q == LC_IDLE) begin
        if (req_valid) begin
          if (!cmd_legal) begin
            bad_cmd <= 1'b1;
          end else if (req_len == '0) begin
            finish <= 1'b1;
          end else begin
            state_q      <= LC_ISSUE;
            piece_valid  <= 1'b1;
            piece_addr   <= req_addr;
            piece_size   <= calc_size;
            piece_offset <= '0;
            piece_cmd    <= req_cmd;
            rem_q        <= calc_rem_after;
            piece_last   <= (calc_rem_after == '0);
          end
        end
      end else if (take_piece) begin
        if (piece_last) begin
          state_q     <= LC_IDLE;
          piece_valid <= 1'b0;
          piece_last  <= 1'b0;
          finish      <= 1'b1;
        end else begin
          piece_addr   <= calc_addr;
          piece_size   <= calc_size;
          piece_offset <= piece_offset + LEN_W'(piece_size);
          rem_q        <= calc_rem_after;
          piece_last   <= (calc_rem_after == '0);
        end
      end
    end
  end

endmodule

// File: rtl/line_chunker_checker.sv
module line_chunker_checker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int LINE_BYTES = 64,
  localparam int LINE_LOG2 = $clog2(LINE_BYTES),
  localparam int SIZE_W    = LINE_LOG2 + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [1:0]        req_cmd,
  input logic              piece_valid,
  input logic              piece_ready,
  input logic [ADDR_W-1:0] piece_addr,
  input logic [SIZE_W-1:0] piece_size,
  input logic [LEN_W-1:0]  piece_offset,
  input logic [1:0]        piece_cmd,
  input logic              piece_last,
  input logic              finish,
  input logic              bad_cmd
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !piece_valid && !finish && !bad_cmd && req_ready);

  assert_ready_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && piece_valid));

  assert_size_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    piece_valid |-> piece_size != '0);

  assert_no_line_cross_R4: assert property (@(posedge clk) disable iff (rst)
    piece_valid |-> (int'(piece_addr[LINE_LOG2-1:0]) + int'(piece_size)) <= LINE_BYTES);

  assert_later_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (piece_valid && piece_offset != '0) |-> piece_addr[LINE_LOG2-1:0] == '0);

  assert_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (piece_valid && piece_ready && !piece_last) |=>
      piece_valid && piece_offset == $past(piece_offset) + LEN_W'($past(piece_size)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (piece_valid && !piece_ready) |=>
      piece_valid && $stable(piece_addr) && $stable(piece_size) &&
      $stable(piece_offset) && $stable(piece_cmd) && $stable(piece_last));

  assert_bad_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_cmd[1]) |=> bad_cmd && !piece_valid && !finish);

  assert_zero_len_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_cmd[1] && req_len == '0) |=> finish && !piece_valid);

  assert_finish_after_last_R10: assert property (@(posedge clk) disable iff (rst)
    (piece_valid && piece_ready && piece_last) |=> finish && !piece_valid && req_ready);

endmodule

bind line_chunker line_chunker_checker #(
  .ADDR_W     (ADDR_W),
  .LEN_W      (LEN_W),
  .LINE_BYTES (LINE_BYTES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_len      (req_len),
  .req_cmd      (req_cmd),
  .piece_valid  (piece_valid),
  .piece_ready  (piece_ready),
  .piece_addr   (piece_addr),
  .piece_size   (piece_size),
  .piece_offset (piece_offset),
  .piece_cmd    (piece_cmd),
  .piece_last   (piece_last),
  .finish       (finish),
  .bad_cmd      (bad_cmd)
);

// File: tb/line_chunker_tb.sv
module line_chunker_tb;
  localparam int ADDR_W     = 32;
  localparam int LEN_W      = 8;
  localparam int LINE_BYTES = 16;
  localparam int SIZE_W     = $clog2(LINE_BYTES) + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [1:0]        req_cmd = 2'b00;
  logic              piece_valid;
  logic              piece_ready = 1'b0;
  logic [ADDR_W-1:0] piece_addr;
  logic [SIZE_W-1:0] piece_size;
  logic [LEN_W-1:0]  piece_offset;
  logic [1:0]        piece_cmd;
  logic              piece_last;
  logic              finish;
  logic              bad_cmd;

  int n_checks = 0;
  int n_errors = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  line_chunker #(
    .ADDR_W (ADDR_W), .LEN_W (LEN_W), .LINE_BYTES (LINE_BYTES)
  ) u_dut (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_len (req_len), .req_cmd (req_cmd),
    .piece_valid (piece_valid), .piece_ready (piece_ready),
    .piece_addr (piece_addr), .piece_size (piece_size),
    .piece_offset (piece_offset), .piece_cmd (piece_cmd),
    .piece_last (piece_last), .finish (finish), .bad_cmd (bad_cmd)
  );

  task automatic check_eq(input string rq, input string what,
                          input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int exp_size(input int unsigned addr, input int rem);
    int room;
    room = LINE_BYTES - int'(addr % LINE_BYTES);
    return (rem < room) ? rem : room;
  endfunction

  task automatic run_req(input int unsigned addr, input int len, input logic [1:0] cmd);
    int unsigned ea;
    int rem;
    int off;
    int sz;
    bit rdy;
    bit held;
    string tg;
    @(negedge clk);
    check_eq("R2", "req_ready when idle", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = addr;
    req_len   = len[LEN_W-1:0];
    req_cmd   = cmd;
    @(negedge clk);
    req_valid = 1'b0;
    if (cmd[1]) begin
      check_eq("R8", "bad_cmd pulse", bad_cmd, 1);
      check_eq("R8", "no piece on bad cmd", piece_valid, 0);
      check_eq("R8", "no finish on bad cmd", finish, 0);
      @(negedge clk);
      check_eq("R8", "bad_cmd one cycle", bad_cmd, 0);
      check_eq("R8", "ready after bad cmd", req_ready, 1);
      return;
    end
    if (len == 0) begin
      check_eq("R9", "finish on zero length", finish, 1);
      check_eq("R9", "no piece on zero length", piece_valid, 0);
      @(negedge clk);
      check_eq("R9", "finish one cycle", finish, 0);
      return;
    end
    ea = addr; rem = len; off = 0; held = 1'b0;
    forever begin
      sz = exp_size(ea, rem);
      tg = (off == 0) ? "R3" : "R4";
      check_eq(tg, "piece_valid", piece_valid, 1);
      check_eq(tg, "piece_addr", piece_addr, ea);
      check_eq(tg, "piece_size", piece_size, sz);
      check_eq("R5", "piece_offset", piece_offset, off);
      check_eq("R7", "piece_cmd", piece_cmd, cmd);
      check_eq("R10", "piece_last", piece_last, (rem == sz) ? 1 : 0);
      check_eq("R2", "req_ready while busy", req_ready, 0);
      if (held) check_eq("R6", "held piece addr", piece_addr, ea);
      rdy = ($urandom % 4) != 0;
      held = !rdy;
      piece_ready = rdy;
      if (!rdy && ($urandom % 2) == 1) begin
        // R2: request attempt while busy must be ignored
        req_valid = 1'b1;
        req_addr  = $urandom;
        req_len   = 8'hFF;
        req_cmd   = 2'b01;
      end
      @(negedge clk);
      req_valid = 1'b0;
      piece_ready = 1'b0;
      if (rdy) begin
        ea += sz; off += sz; rem -= sz;
        if (rem == 0) begin
          check_eq("R10", "finish after last", finish, 1);
          check_eq("R10", "valid drops after last", piece_valid, 0);
          check_eq("R2", "ready after last", req_ready, 1);
          @(negedge clk);
          check_eq("R10", "finish one cycle", finish, 0);
          break;
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_eq("R1", "valid in reset", piece_valid, 0);
    check_eq("R1", "finish in reset", finish, 0);
    check_eq("R1", "bad_cmd in reset", bad_cmd, 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "ready after reset", req_ready, 1);
    check_eq("R1", "valid after reset", piece_valid, 0);

    run_req(32'h0000_1000, 16, 2'b00);   // one aligned full line
    run_req(32'h0000_100F, 1, 2'b01);    // last byte of a line
    run_req(32'h0000_100F, 2, 2'b00);    // crosses one boundary
    run_req(32'h0000_2003, 13, 2'b01);   // ends exactly on a boundary
    run_req(32'h0000_3007, 255, 2'b01);  // long run, partial remainder
    run_req(32'h0000_4000, 0, 2'b00);    // zero length
    run_req(32'h0000_4000, 20, 2'b10);   // illegal command
    run_req(32'h0000_4000, 20, 2'b11);   // illegal command
    for (int i = 0; i < 300; i++) begin
      int unsigned a;
      int l;
      logic [1:0] c;
      a = $urandom % 32'h7FFF_0000;
      l = int'($urandom % 256);
      if (($urandom % 10) == 0) l = 0;
      c = (($urandom % 8) == 0) ? 2'(2 + ($urandom % 2)) : 2'($urandom % 2);
      run_req(a, l, c);
    end
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule